// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding Selector

This block sits in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It chooses the two source operands handed to the instruction in decode. Each operand is either the value read from the register file or a newer value that is still in flight in a later stage. For call and jump instructions, the A operand is the incremented program counter instead.

Three pipeline registers feed values back to decode. The execute stage supplies the result its ALU is computing in the current cycle. The memory stage supplies its load data and its ALU result. The write-back stage supplies its load data and its ALU result. A fixed priority chain lets the youngest producer win, so decode always sees the value a sequential machine would have written last.

The block is purely combinational. It settles within the cycle in which its inputs change, and it holds no state. Register file, ALU, memories and stall control lie outside it.

Top module: `fwd_sel`

## Requirements
- R1: When the decode instruction code is 4'h8 (call) or 4'h7 (jump), `op_a` equals `pc_inc`, whatever any stage holds.
- R2: Otherwise `op_a` takes the first match, in this order:
  - the execute ALU result (`ex_dst`),
  - memory load data (`mem_dstm`),
  - memory ALU result (`mem_dste`),
  - write-back load data (`wb_dstm`),
  - write-back ALU result (`wb_dste`).
  A match means the source ID equals that destination ID.
- R3: When no stage matches, an operand equals its register-file read value (`rf_a` or `rf_b`).
- R4: Register ID 4'hF means "no register". It never produces a match, whether it appears as a source or as a destination.
- R5: `op_b` uses the same five-stage chain as `op_a` but has no program-counter case. The instruction code has no effect on `op_b`.
- R6: The outputs depend only on the present inputs. A new input pattern shows at the outputs within the same clock cycle.
- R7: When a register matches several stages at once, the youngest matching stage always supplies the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_code | input | 4 | instruction code in decode |
| d_src_a | input | 4 | A source register ID |
| d_src_b | input | 4 | B source register ID |
| rf_a | input | 32 | register-file read value for A |
| rf_b | input | 32 | register-file read value for B |
| pc_inc | input | 32 | incremented PC of the decode instruction |
| ex_dst | input | 4 | execute-stage ALU destination ID |
| ex_val | input | 32 | ALU result being computed in execute |
| mem_dstm | input | 4 | memory-stage load destination ID |
| mem_rdata | input | 32 | data read by the memory stage |
| mem_dste | input | 4 | memory-stage ALU destination ID |
| mem_alu | input | 32 | ALU result held in the memory stage |
| wb_dstm | input | 4 | write-back load destination ID |
| wb_rdata | input | 32 | load data held in write-back |
| wb_dste | input | 4 | write-back ALU destination ID |
| wb_alu | input | 32 | ALU result held in write-back |
| op_a | output | 32 | selected A operand |
| op_b | output | 32 | selected B operand |

## Verification
The bench sets one register in every stage at once, then removes stages one at a time from the young end. The chosen source must step down the chain. A design with two priorities swapped, for example the memory ALU result ahead of memory load data, would return a stale value at exactly one of those steps.

Patterns with ID 4'hF as both source and destination catch a design that forwards on the "no register" ID. A call or jump whose A source also matches the execute stage catches a design that checks the program-counter case too late in the chain.

Call and jump codes are also placed next to B operands that match a stage. This catches a design that lets the program-counter case leak onto `op_b`.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int RID_W   = 4;
  localparam int DATA_W  = 32;
  localparam int CODE_W  = 4;
  localparam int N_STAGE = 5;
  localparam logic [RID_W-1:0]  NO_REG    = 4'hF;
  localparam logic [CODE_W-1:0] CODE_JUMP = 4'h7;
  localparam logic [CODE_W-1:0] CODE_CALL = 4'h8;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int RW = 4,
  parameter logic [RW-1:0] NONE_ID = '1
) (
  input  logic [RW-1:0] src_id,
  input  logic [RW-1:0] dst_id,
  output logic          hit
);
  always_comb hit = (src_id != NONE_ID) && (src_id == dst_id);
endmodule

// File: rtl/fwd_pc_dec.sv
module fwd_pc_dec #(
  parameter int CW = 4,
  parameter logic [CW-1:0] CODE_X = '0,
  parameter logic [CW-1:0] CODE_Y = '0
) (
  input  logic [CW-1:0] code,
  output logic          pc_op
);
  always_comb pc_op = (code == CODE_X) || (code == CODE_Y);
endmodule

// File: rtl/fwd_chain.sv
module fwd_chain #(
  parameter int RW = 4,
  parameter int DW = 32,
  parameter int NS = 5,
  parameter logic [RW-1:0] NONE_ID = '1,
  parameter bit USE_PC = 1'b0
) (
  input  logic [RW-1:0]         src_id,
  input  logic [DW-1:0]         rval,
  input  logic [DW-1:0]         pc,
  input  logic                  pc_op,
  input  logic [NS-1:0][RW-1:0] dst_ids,
  input  logic [NS-1:0][DW-1:0] vals,
  output logic [DW-1:0]         res
);
  logic [NS-1:0] hit;
  logic          take_pc;

  for (genvar i = 0; i < NS; i++) begin : g_cmp
    fwd_match #(.RW(RW), .NONE_ID(NONE_ID)) u_m (
      .src_id(src_id),
      .dst_id(dst_ids[i]),
      .hit   (hit[i])
    );
  end

  if (USE_PC) begin : g_pc
    always_comb take_pc = pc_op;
  end else begin : g_nopc
    always_comb take_pc = 1'b0;
  end

  // index 0 is the youngest stage; scanning from the oldest end lets it win
  always_comb begin
    res = rval;
    for (int i = NS - 1; i >= 0; i--) begin
      if (hit[i]) res = vals[i];
    end
    if (take_pc) res = pc;
  end

  always_comb begin
    if (take_pc) begin
      // R1
      pc_wins_chk: assert (res == pc);
    end else if (hit[0]) begin
      // R7
      young_wins_chk: assert (res == vals[0]);
    end else if (hit == '0) begin
      // R3
      rf_pass_chk: assert (res == rval);
    end
    if (src_id == NONE_ID && !take_pc) begin
      // R4
      none_id_chk: assert (res == rval);
    end
  end
endmodule

// File: rtl/fwd_sel.sv
module fwd_sel
  import fwd_pkg::*;
(
  input  logic [CODE_W-1:0] d_code,
  input  logic [RID_W-1:0]  d_src_a,
  input  logic [RID_W-1:0]  d_src_b,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [DATA_W-1:0] pc_inc,
  input  logic [RID_W-1:0]  ex_dst,
  input  logic [DATA_W-1:0] ex_val,
  input  logic [RID_W-1:0]  mem_dstm,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [RID_W-1:0]  mem_dste,
  input  logic [DATA_W-1:0] mem_alu,
  input  logic [RID_W-1:0]  wb_dstm,
  input  logic [DATA_W-1:0] wb_rdata,
  input  logic [RID_W-1:0]  wb_dste,
  input  logic [DATA_W-1:0] wb_alu,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b
);
  logic [N_STAGE-1:0][RID_W-1:0]  dsts;
  logic [N_STAGE-1:0][DATA_W-1:0] vals;
  logic                           pc_op;

  // priority order, youngest first
  always_comb begin
    dsts[0] = ex_dst;   vals[0] = ex_val;
    dsts[1] = mem_dstm; vals[1] = mem_rdata;
    dsts[2] = mem_dste; vals[2] = mem_alu;
    dsts[3] = wb_dstm;  vals[3] = wb_rdata;
    dsts[4] = wb_dste;  vals[4] = wb_alu;
  end

  fwd_pc_dec #(.CW(CODE_W), .CODE_X(CODE_CALL), .CODE_Y(CODE_JUMP)) u_dec (
    .code (d_code),
    .pc_op(pc_op)
  );

  fwd_chain #(.RW(RID_W), .DW(DATA_W), .NS(N_STAGE), .NONE_ID(NO_REG), .USE_PC(1'b1)) u_a (
    .src_id(d_src_a), .rval(rf_a), .pc(pc_inc), .pc_op(pc_op),
    .dst_ids(dsts), .vals(vals), .res(op_a)
  );

  fwd_chain #(.RW(RID_W), .DW(DATA_W), .NS(N_STAGE), .NONE_ID(NO_REG), .USE_PC(1'b0)) u_b (
    .src_id(d_src_b), .rval(rf_b), .pc(pc_inc), .pc_op(pc_op),
    .dst_ids(dsts), .vals(vals), .res(op_b)
  );

  always_comb begin
    if (d_src_b == NO_REG) begin
      // R5
      b_none_chk: assert (op_b == rf_b);
    end
    if (!pc_op && d_src_a == d_src_b) begin
      // R5
      b_same_chain_chk: assert ((op_a == rf_a) == (op_b == rf_b) || rf_a == rf_b);
    end
  end
endmodule

// File: tb/sim_fwd_sel.sv
module sim_fwd_sel;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [3:0]  d_code, d_src_a, d_src_b;
  logic [3:0]  ex_dst, mem_dstm, mem_dste, wb_dstm, wb_dste;
  logic [31:0] rf_a, rf_b, pc_inc, ex_val, mem_rdata, mem_alu, wb_rdata, wb_alu;
  logic [31:0] op_a, op_b;
  int total = 0;
  int bad = 0;

  fwd_sel u0 (
    .d_code(d_code), .d_src_a(d_src_a), .d_src_b(d_src_b),
    .rf_a(rf_a), .rf_b(rf_b), .pc_inc(pc_inc),
    .ex_dst(ex_dst), .ex_val(ex_val),
    .mem_dstm(mem_dstm), .mem_rdata(mem_rdata),
    .mem_dste(mem_dste), .mem_alu(mem_alu),
    .wb_dstm(wb_dstm), .wb_rdata(wb_rdata),
    .wb_dste(wb_dste), .wb_alu(wb_alu),
    .op_a(op_a), .op_b(op_b)
  );

  // source index: 0 ex, 1 mem load, 2 mem alu, 3 wb load, 4 wb alu, 5 regfile, 6 pc
  function automatic logic [31:0] expect_val(input int idx, input bit port_b);
    case (idx)
      0: return 32'h1E1E_0000;
      1: return 32'h2A2A_0001;
      2: return 32'h3C3C_0002;
      3: return 32'h4D4D_0003;
      4: return 32'h5F5F_0004;
      5: return port_b ? 32'hB0B0_0005 : 32'hA0A0_0005;
      default: return 32'h0000_4C6E;
    endcase
  endfunction

  // {code, srcA, srcB, exd, memM, memE, wbM, wbE, expA, expB}
  localparam logic [39:0] VEC [13] = '{
    40'h0_3_5_3_3_3_3_3_0_5,
    40'h0_3_1_1_3_3_3_3_1_0,
    40'h0_3_2_1_2_3_3_3_2_1,
    40'h0_3_4_1_2_4_3_3_3_2,
    40'h0_3_6_1_2_4_6_3_4_3,
    40'h0_3_7_1_2_4_6_7_5_4,
    40'h8_3_3_3_3_3_3_3_6_0,
    40'h7_F_F_F_F_F_F_F_6_5,
    40'h0_F_F_F_F_F_F_F_5_5,
    40'h0_F_3_3_F_F_F_F_5_0,
    40'h5_9_0_0_9_0_0_9_1_0,
    40'h0_0_0_F_F_0_0_0_2_2,
    40'h8_F_2_F_F_F_2_F_6_3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, sa, sb, e, mm, me, wm, we);
    @(posedge clk);
    d_code = c; d_src_a = sa; d_src_b = sb;
    ex_dst = e; mem_dstm = mm; mem_dste = me; wb_dstm = wm; wb_dste = we;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rf_a = expect_val(5, 1'b0); rf_b = expect_val(5, 1'b1); pc_inc = expect_val(6, 1'b0);
    ex_val = expect_val(0, 1'b0); mem_rdata = expect_val(1, 1'b0); mem_alu = expect_val(2, 1'b0);
    wb_rdata = expect_val(3, 1'b0); wb_alu = expect_val(4, 1'b0);
    d_code = 4'h0; d_src_a = 4'hF; d_src_b = 4'hF;
    ex_dst = 4'hF; mem_dstm = 4'hF; mem_dste = 4'hF; wb_dstm = 4'hF; wb_dste = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 reset A", op_a, expect_val(5, 1'b0));
    check("R3 reset B", op_b, expect_val(5, 1'b1));
    rst = 1'b0;

    // table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < 13; v++) begin
      apply(VEC[v][39:36], VEC[v][35:32], VEC[v][31:28], VEC[v][27:24],
            VEC[v][23:20], VEC[v][19:16], VEC[v][15:12], VEC[v][11:8]);
      check("R2 R6 table A", op_a, expect_val(int'(VEC[v][7:4]), 1'b0));
      check("R5 table B", op_b, expect_val(int'(VEC[v][3:0]), 1'b1));
    end

    // R7: every register in all stages, youngest stages removed one by one
    for (int r = 0; r < 15; r++) begin
      for (int k = 0; k < 6; k++) begin
        apply(4'h0, 4'(r), 4'(r),
              (k > 0) ? 4'hF : 4'(r), (k > 1) ? 4'hF : 4'(r), (k > 2) ? 4'hF : 4'(r),
              (k > 3) ? 4'hF : 4'(r), (k > 4) ? 4'hF : 4'(r));
        check("R7 youngest A", op_a, expect_val(k, 1'b0));
        check("R7 youngest B", op_b, expect_val(k, 1'b1));
      end
    end

    // R4: no-register ID as source and destination everywhere, with ID F in the stages
    apply(4'h0, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF);
    check("R4 none A", op_a, expect_val(5, 1'b0));
    check("R4 none B", op_b, expect_val(5, 1'b1));

    // R1: jump code with A matching execute; R5: B unaffected by the code
    apply(4'h7, 4'h2, 4'h2, 4'h2, 4'h2, 4'hF, 4'hF, 4'hF);
    check("R1 jump A", op_a, expect_val(6, 1'b0));
    check("R5 code ignored B", op_b, expect_val(0, 1'b1));
    apply(4'h6, 4'h2, 4'h2, 4'h2, 4'h2, 4'hF, 4'hF, 4'hF);
    check("R1 non-pc code A", op_a, expect_val(0, 1'b0));

    // R6: value change on a stage shows in the same cycle
    @(posedge clk);
    ex_val = 32'h7777_1234;
    @(negedge clk);
    check("R6 same cycle A", op_a, 32'h7777_1234);
    check("R6 same cycle B", op_b, 32'h7777_1234);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule